// File: doc/BRIEF.md
# Cache Maintenance Command Decoder

This block sits behind the coprocessor port of a processor core and turns each access to the cache maintenance register into either a single command strobe or an undefined-instruction trap. A request carries its direction, whether it uses the single-register or the dual-register form, the three-bit major opcode, the four-bit CRm field and the three-bit minor opcode. It also carries a flag for user (unprivileged) mode and the two operand registers.

The decoder does three things. It checks each encoding against the trap rules. It lets a set of unified-cache encodings through silently as legal no-ops. It restricts user mode to four operations. The result is registered and appears one cycle after the request, as a one-hot command vector or a trap pulse. The operand registers are forwarded with the command; range commands get cache-line-aligned start and end addresses. Walking the cache, executing barriers and iterating over a range are left to the units that consume the strobe.

Top module: `cmo_decoder`

## Requirements
- R1: A request whose major opcode `req_opc1` is not zero traps, whatever its other fields.
- R2: A read is accepted only in the single-register form with CRm=4, Opcode_2=0 (command bit 9, address-translation result read) or CRm=10, Opcode_2=6 (command bit 10, dirty-status read). Every other read traps, including every dual-register read.
- R3: A single-register write to CRm=10, Opcode_2=6 (the dirty-status register) traps.
- R4: A dual-register write selects a range command by CRm alone: 5 gives bit 11 (invalidate instruction range), 6 gives bit 12 (invalidate data range), 12 gives bit 13 (clean data range) and 14 gives bit 14 (clean and invalidate data range). Any other CRm traps.
- R5: Single-register writes decode {CRm,Opcode_2} as follows: 7,0 to bit 0; 5,0 to bit 1; 5,4 to bit 2 (flush prefetch buffer); 6,0 to bit 3; 10,0 to bit 4; 10,4 to bit 5 (synchronization barrier); 10,5 to bit 6 (memory barrier); 14,0 to bit 7; 4,0 to bit 8 (address-translation register write).
- R6: From a privileged mode, a single-register write with CRm=7 and Opcode_2 from 1 to 7, or with CRm=11 or CRm=15 and any Opcode_2, gives neither a trap nor a command.
- R7: A single-register write with any other {CRm,Opcode_2} traps.
- R8: With `req_user` high, only bits 2, 5, 6 and 13 may be issued. Every other access traps, including the no-op encodings and the permitted reads.
- R9: `cmd_oh` and `undef_trap` are registered. They are valid only in the cycle after a `req_valid` cycle and are zero in every other cycle and during reset. `cmd_oh` has at most one bit set, and the trap and a command never coincide.
- R10: With a range command, `opnd_a` and `opnd_b` carry `req_rd` and `req_rn` with the low LINE_W bits cleared. With any other command, `opnd_a` carries `req_rd` and `opnd_b` is zero. With a trap, a no-op or an idle cycle, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_dual | input | 1 | 1 for the dual-register (range) form |
| req_opc1 | input | 3 | Major opcode |
| req_crm | input | 4 | CRm field |
| req_opc2 | input | 3 | Minor opcode |
| req_user | input | 1 | Request issued in user mode |
| req_rd | input | DATA_W | First operand register |
| req_rn | input | DATA_W | Second operand register (dual form) |
| cmd_oh | output | 15 | One-hot operation command, one cycle after the request |
| undef_trap | output | 1 | Undefined-instruction trap, one cycle after the request |
| opnd_a | output | DATA_W | Forwarded first operand / range start |
| opnd_b | output | DATA_W | Forwarded second operand / range end |

## Verification
Every result is due exactly one clock after the `req_valid` cycle that caused it: the trap, the command bit and both operands. In all other cycles, every output is expected to be zero. The bench drives each request on a falling edge and computes that request's expectation from a behavioural model. At the next falling edge it compares all four outputs, so each comparison falls one full register stage after its stimulus. Back-to-back requests and requests separated by idle gaps both occur, so a held-over or a missing output is caught in the cycle it appears.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  localparam int OPC1_W  = 3;
  localparam int CRM_W   = 4;
  localparam int OPC2_W  = 3;
  localparam int NUM_OPS = 15;

  typedef enum logic [3:0] {
    OP_INV_BOTH_ALL = 4'd0,
    OP_INV_I_ALL    = 4'd1,
    OP_FLUSH_PFB    = 4'd2,
    OP_INV_D_ALL    = 4'd3,
    OP_CLEAN_D_ALL  = 4'd4,
    OP_SYNC_BAR     = 4'd5,
    OP_MEM_BAR      = 4'd6,
    OP_CLNINV_D_ALL = 4'd7,
    OP_XLAT_WR      = 4'd8,
    OP_XLAT_RD      = 4'd9,
    OP_DIRTY_RD     = 4'd10,
    OP_RNG_INV_I    = 4'd11,
    OP_RNG_INV_D    = 4'd12,
    OP_RNG_CLEAN_D  = 4'd13,
    OP_RNG_CLNINV_D = 4'd14
  } cmo_op_e;

  typedef struct packed {
    logic    hit;
    logic    noop;
    cmo_op_e op;
  } cmo_dec_t;

  function automatic logic user_allowed(cmo_op_e op);
    case (op)
      OP_FLUSH_PFB, OP_SYNC_BAR, OP_MEM_BAR, OP_RNG_CLEAN_D: user_allowed = 1'b1;
      default:                                              user_allowed = 1'b0;
    endcase
  endfunction

  function automatic logic is_range(cmo_op_e op);
    is_range = (op >= OP_RNG_INV_I);
  endfunction
endpackage

// File: rtl/cmo_single_dec.sv
module cmo_single_dec
  import cmo_pkg::*;
(
  input  logic              is_write,
  input  logic [CRM_W-1:0]  crm,
  input  logic [OPC2_W-1:0] opc2,
  output cmo_dec_t          res
);
  always_comb begin
    res = '{hit: 1'b0, noop: 1'b0, op: OP_INV_BOTH_ALL};
    if (!is_write) begin
      if (crm == 4'd4 && opc2 == 3'd0) begin
        res.hit = 1'b1; res.op = OP_XLAT_RD;
      end else if (crm == 4'd10 && opc2 == 3'd6) begin
        res.hit = 1'b1; res.op = OP_DIRTY_RD;
      end
    end else begin
      case (crm)
        4'd4: if (opc2 == 3'd0) begin res.hit = 1'b1; res.op = OP_XLAT_WR; end
        4'd5: begin
          if (opc2 == 3'd0)      begin res.hit = 1'b1; res.op = OP_INV_I_ALL; end
          else if (opc2 == 3'd4) begin res.hit = 1'b1; res.op = OP_FLUSH_PFB; end
        end
        4'd6: if (opc2 == 3'd0) begin res.hit = 1'b1; res.op = OP_INV_D_ALL; end
        4'd7: begin
          if (opc2 == 3'd0) begin res.hit = 1'b1; res.op = OP_INV_BOTH_ALL; end
          else              res.noop = 1'b1;
        end
        4'd10: begin
          case (opc2)
            3'd0:    begin res.hit = 1'b1; res.op = OP_CLEAN_D_ALL; end
            3'd4:    begin res.hit = 1'b1; res.op = OP_SYNC_BAR; end
            3'd5:    begin res.hit = 1'b1; res.op = OP_MEM_BAR; end
            default: res.hit = 1'b0;
          endcase
        end
        4'd11, 4'd15: res.noop = 1'b1;
        4'd14: if (opc2 == 3'd0) begin res.hit = 1'b1; res.op = OP_CLNINV_D_ALL; end
        default: res.hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmo_range_dec.sv
module cmo_range_dec
  import cmo_pkg::*;
(
  input  logic             is_write,
  input  logic [CRM_W-1:0] crm,
  output cmo_dec_t         res
);
  always_comb begin
    res = '{hit: 1'b0, noop: 1'b0, op: OP_RNG_INV_I};
    if (is_write) begin
      case (crm)
        4'd5:    begin res.hit = 1'b1; res.op = OP_RNG_INV_I; end
        4'd6:    begin res.hit = 1'b1; res.op = OP_RNG_INV_D; end
        4'd12:   begin res.hit = 1'b1; res.op = OP_RNG_CLEAN_D; end
        4'd14:   begin res.hit = 1'b1; res.op = OP_RNG_CLNINV_D; end
        default: res.hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmo_decoder.sv
module cmo_decoder
  import cmo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_dual,
  input  logic [OPC1_W-1:0]  req_opc1,
  input  logic [CRM_W-1:0]   req_crm,
  input  logic [OPC2_W-1:0]  req_opc2,
  input  logic               req_user,
  input  logic [DATA_W-1:0]  req_rd,
  input  logic [DATA_W-1:0]  req_rn,
  output logic [NUM_OPS-1:0] cmd_oh,
  output logic               undef_trap,
  output logic [DATA_W-1:0]  opnd_a,
  output logic [DATA_W-1:0]  opnd_b
);
  localparam logic [DATA_W-1:0] LINE_MASK = {{(DATA_W-LINE_W){1'b1}}, {LINE_W{1'b0}}};

  cmo_dec_t single_res, range_res, sel_res;

  cmo_single_dec u_single (
    .is_write (req_write),
    .crm      (req_crm),
    .opc2     (req_opc2),
    .res      (single_res)
  );

  cmo_range_dec u_range (
    .is_write (req_write),
    .crm      (req_crm),
    .res      (range_res)
  );

  logic accept, trap_next;
  logic [NUM_OPS-1:0] oh_next;
  logic [DATA_W-1:0]  a_next, b_next;

  always_comb begin
    sel_res = req_dual ? range_res : single_res;
    accept  = 1'b0;
    trap_next = 1'b0;
    if (req_valid) begin
      if (req_opc1 != '0) begin
        trap_next = 1'b1;
      end else if (req_user) begin
        accept    = sel_res.hit && user_allowed(sel_res.op);
        trap_next = !accept;
      end else begin
        accept    = sel_res.hit;
        trap_next = !sel_res.hit && !sel_res.noop;
      end
    end
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_oh
    assign oh_next[i] = accept && (sel_res.op == cmo_op_e'(i));
  end

  always_comb begin
    a_next = '0;
    b_next = '0;
    if (accept) begin
      if (is_range(sel_res.op)) begin
        a_next = req_rd & LINE_MASK;
        b_next = req_rn & LINE_MASK;
      end else begin
        a_next = req_rd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_oh     <= '0;
      undef_trap <= 1'b0;
      opnd_a     <= '0;
      opnd_b     <= '0;
    end else begin
      cmd_oh     <= oh_next;
      undef_trap <= trap_next;
      opnd_a     <= a_next;
      opnd_b     <= b_next;
    end
  end

  localparam int RNG_LO = int'(OP_RNG_INV_I);

  AST_OPC1_TRAP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_opc1 != '0 |=> undef_trap && cmd_oh == '0); // R1
  AST_DUAL_READ_TRAP: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_dual |=> undef_trap); // R2
  AST_DIRTY_WR_TRAP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && !req_dual && req_crm == 4'd10 && req_opc2 == 3'd6 |=> undef_trap); // R3
  AST_NOOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_user && req_opc1 == '0 && req_write && !req_dual &&
    (req_crm == 4'd11 || req_crm == 4'd15) |=> !undef_trap && cmd_oh == '0); // R6
  AST_USER_TRAP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_user && !req_dual && req_crm != 4'd5 && req_crm != 4'd10 |=> undef_trap); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !undef_trap && cmd_oh == '0); // R9
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_oh)); // R9
  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    undef_trap |-> cmd_oh == '0 && opnd_a == '0); // R9
  AST_RANGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    |cmd_oh[NUM_OPS-1:RNG_LO] |-> opnd_a[LINE_W-1:0] == '0 && opnd_b[LINE_W-1:0] == '0); // R10
endmodule

// File: tb/tb_cmo_decoder.sv
`timescale 1ns/1ps
module tb_cmo_decoder;
  localparam int DW = 32;
  localparam int NOPS = 15;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, req_valid, req_write, req_dual, req_user;
  logic [2:0] req_opc1, req_opc2;
  logic [3:0] req_crm;
  logic [DW-1:0] req_rd, req_rn;
  logic [NOPS-1:0] cmd_oh;
  logic undef_trap;
  logic [DW-1:0] opnd_a, opnd_b;

  cmo_decoder #(.DATA_W(DW), .LINE_W(5)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_dual(req_dual), .req_opc1(req_opc1), .req_crm(req_crm),
    .req_opc2(req_opc2), .req_user(req_user), .req_rd(req_rd), .req_rn(req_rn),
    .cmd_oh(cmd_oh), .undef_trap(undef_trap), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NOPS-1:0] e_oh = '0;
  logic e_trap = 1'b0;
  logic [DW-1:0] e_a = '0, e_b = '0;
  string e_tag = "R9";

  // Behavioural reference: returns op index (-1 = none), trap, and the rule that decided it.
  function automatic void model(input bit w, input bit d, input bit u, input int o1,
                                input int crm, input int o2,
                                output int op, output bit trap, output string tag);
    op = -1; trap = 0; tag = "R7";
    if (o1 != 0) begin trap = 1; tag = "R1"; return; end
    if (!w) begin
      tag = "R2";
      if (!d && crm == 4 && o2 == 0) op = 9;
      else if (!d && crm == 10 && o2 == 6) op = 10;
      else trap = 1;
    end else if (d) begin
      tag = "R4";
      if (crm == 5) op = 11;
      else if (crm == 6) op = 12;
      else if (crm == 12) op = 13;
      else if (crm == 14) op = 14;
      else trap = 1;
    end else if (crm == 10 && o2 == 6) begin
      trap = 1; tag = "R3";
    end else begin
      tag = "R5";
      if (crm == 7 && o2 == 0) op = 0;
      else if (crm == 5 && o2 == 0) op = 1;
      else if (crm == 5 && o2 == 4) op = 2;
      else if (crm == 6 && o2 == 0) op = 3;
      else if (crm == 10 && o2 == 0) op = 4;
      else if (crm == 10 && o2 == 4) op = 5;
      else if (crm == 10 && o2 == 5) op = 6;
      else if (crm == 14 && o2 == 0) op = 7;
      else if (crm == 4 && o2 == 0) op = 8;
      else if (crm == 7 || crm == 11 || crm == 15) tag = "R6";
      else begin trap = 1; tag = "R7"; end
    end
    if (u && !trap && !(op == 2 || op == 5 || op == 6 || op == 13)) begin
      op = -1; trap = 1; tag = "R8";
    end
  endfunction

  task automatic compare();
    checks++;
    if (cmd_oh !== e_oh || undef_trap !== e_trap) begin
      fails++;
      $display("FAIL %s cmd/trap: got cmd=%h trap=%b exp cmd=%h trap=%b", e_tag, cmd_oh, undef_trap, e_oh, e_trap);
    end
    checks++;
    if (opnd_a !== e_a || opnd_b !== e_b) begin
      fails++;
      $display("FAIL R10 (%s) operands: got a=%h b=%h exp a=%h b=%h", e_tag, opnd_a, opnd_b, e_a, e_b);
    end
  endtask

  task automatic drive(input bit v, input bit w, input bit d, input bit u,
                       input int o1, input int crm, input int o2);
    int op; bit trap; string tag;
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_dual = d; req_user = u;
    req_opc1 = 3'(o1); req_crm = 4'(crm); req_opc2 = 3'(o2);
    req_rd = $urandom; req_rn = $urandom;
    e_oh = '0; e_trap = 1'b0; e_a = '0; e_b = '0; e_tag = "R9";
    if (v) begin
      model(w, d, u, o1, crm, o2, op, trap, tag);
      e_tag = tag;
      e_trap = trap;
      if (op >= 0) begin
        e_oh[op] = 1'b1;
        if (op >= 11) begin
          e_a = req_rd & ~32'h1f;
          e_b = req_rn & ~32'h1f;
        end else begin
          e_a = req_rd;
        end
      end
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_dual = 0; req_user = 0;
    req_opc1 = 0; req_crm = 0; req_opc2 = 0; req_rd = 0; req_rn = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_oh !== '0 || undef_trap !== 1'b0 || opnd_a !== '0 || opnd_b !== '0) begin
      fails++;
      $display("FAIL R9 reset: got cmd=%h trap=%b a=%h b=%h exp all zero", cmd_oh, undef_trap, opnd_a, opnd_b);
    end
    rst = 1'b0;
    // Directed cases
    drive(1, 1, 0, 0, 1, 10, 4);   // R1 opcode 1 nonzero
    drive(1, 0, 0, 0, 0, 4, 0);    // R2 translation read
    drive(1, 0, 0, 0, 0, 10, 6);   // R2 dirty read
    drive(1, 0, 1, 0, 0, 12, 0);   // R2 dual read traps
    drive(1, 1, 0, 0, 0, 10, 6);   // R3 dirty write traps
    drive(1, 1, 1, 0, 0, 12, 0);   // R4 range clean
    drive(1, 1, 1, 0, 0, 7, 0);    // R4 bad range CRm
    drive(1, 1, 0, 0, 0, 10, 5);   // R5 memory barrier
    drive(0, 0, 0, 0, 0, 0, 0);    // R9 idle
    drive(1, 1, 0, 0, 0, 7, 3);    // R6 no-op
    drive(1, 1, 0, 0, 0, 15, 0);   // R6 no-op
    drive(1, 1, 0, 0, 0, 9, 0);    // R7 undefined
    drive(1, 1, 0, 1, 0, 10, 4);   // R8 user barrier allowed
    drive(1, 1, 1, 1, 0, 12, 0);   // R8 user range clean allowed
    drive(1, 1, 0, 1, 0, 11, 2);   // R8 user no-op traps
    drive(1, 0, 0, 1, 0, 10, 6);   // R8 user dirty read traps
    drive(1, 1, 1, 1, 0, 14, 0);   // R8 user clean+inv range traps
    // Exhaustive sweep with opcode 1 = 0, idle gaps interleaved
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int u = 0; u < 2; u++)
          for (int c = 0; c < 16; c++)
            for (int o = 0; o < 8; o++) begin
              drive(1, w[0], d[0], u[0], 0, c, o);
              if (((c + o) % 5) == 0) drive(0, 1, 0, 0, 0, c, o);
            end
    // Nonzero opcode 1 sweep (R1)
    for (int o1 = 1; o1 < 8; o1++)
      for (int c = 0; c < 16; c += 3)
        drive(1, 1, o1[0], 0, o1, c, 4);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired: got hung run exp completion");
      finish_run();
    end
  end
endmodule